// File: doc/BRIEF.md
# Unicast Destination Address Filter

This block watches a byte-wide receive stream and decides, for each frame, whether its destination address is addressed to this station. It compares the first six bytes of the frame against a 48-bit station address held in its own register. The comparison proceeds one byte per valid strobe. When the sixth address byte arrives, the block issues a single-cycle decision pulse, together with an accept flag. A frame counts as unicast when bit 0 of its first byte is clear. Only unicast frames can be accepted. A separate control input disables unicast acceptance.

The station address register has two write paths: a nonvolatile-memory load path and a host initialization-block load path. Elsewhere it is read-only, and its value is visible on an output. The register holds zero while the reset is applied, while the nonvolatile load is pending, and after that load reports a read error. The comparison for a frame uses a copy of the register taken at start-of-frame. A load that arrives in the middle of a frame therefore applies from the next frame onward.

Top module: `ucf_top`

## Requirements
- R1: `is_ucast` becomes 1 in the cycle after the start-of-frame byte if bit 0 of that byte is 0, and 0 if that bit is 1. It holds that value until the next start-of-frame byte.
- R2: Destination byte k (k = 0 for the byte that carries start-of-frame) is compared with `sta_addr[8k+7:8k]`. Bytes in any other order do not match.
- R3: A frame whose first byte has bit 0 equal to 1 never raises `accept`, whatever the register holds.
- R4: When `ucast_dis` is 1 in the cycle of the sixth address byte, `dec_vld` still pulses but `accept` stays 0.
- R5: `sta_addr` reads zero after reset. It also reads zero in the cycle after any cycle in which `nv_pend` or `nv_err` is 1, and these two inputs override any write in that cycle.
- R6: `sta_addr` takes `nv_data` one cycle after `nv_we`, and takes `host_data` one cycle after `host_we`. If both write strobes are 1 in the same cycle, `nv_data` wins. With no write and no clear, the register keeps its value.
- R7: `dec_vld` is a one-cycle pulse in the cycle after the sixth valid address byte. `accept` is 1 in that same cycle exactly when the frame is unicast, all 48 bits match, and the block is not disabled. `accept` is never 1 without `dec_vld`.
- R8: A frame that receives fewer than six bytes before the next start-of-frame produces no decision. Valid bytes after the sixth byte produce no further decision. Valid bytes received before the first start-of-frame after reset produce no decision.
- R9: A frame is compared against the register value held at its start-of-frame edge. A write during the frame, including one in the start-of-frame cycle itself, affects only later frames.
- R10: Idle cycles with `rx_vld` at 0 between address bytes neither advance nor disturb the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sof | input | 1 | Marks the first byte of a frame; valid only when `rx_vld` is 1 |
| rx_vld | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Receive byte |
| ucast_dis | input | 1 | Suppresses unicast acceptance |
| nv_pend | input | 1 | Nonvolatile load not yet complete; clears the register |
| nv_err | input | 1 | Nonvolatile read failed; clears the register |
| nv_we | input | 1 | Write strobe from the nonvolatile load path |
| nv_data | input | 48 | Address from the nonvolatile load path |
| host_we | input | 1 | Write strobe from the host initialization-block path |
| host_data | input | 48 | Address from the host initialization-block path |
| sta_addr | output | 48 | Current station address, read-only view |
| is_ucast | output | 1 | The current frame has a unicast destination |
| dec_vld | output | 1 | Decision pulse after the sixth address byte |
| accept | output | 1 | The frame is accepted; valid when `dec_vld` is 1 |

## Verification
The hardest case to produce from the ports is a station-address write that lands inside a frame. Getting there means placing the host write strobe on a chosen byte of a frame that is already in flight. The expected decision must then come from the old address, and the following frame must be judged against the new one. The bench's frame driver takes the index of a byte at which to raise the host write. The driver computes its expected result from the address the bench held when the frame started, and updates that mirror only after the write. Short frames cut off by a new start-of-frame, and stray bytes sent before any start-of-frame, are covered by the scoreboard: any decision that was not pushed into the queue is reported as a failure.

// File: rtl/ucf_pkg.sv
// Shared definitions for the unicast destination filter.
// Assumes byte-wide receive data and whole-byte address lanes.
package ucf_pkg;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Source selected for the next station register value.
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_CLEAR = 2'd1,
        SRC_NVM   = 2'd2,
        SRC_HOST  = 2'd3
    } addr_src_e;
endpackage

// File: rtl/ucf_sta_reg.sv
// Station address register with its write arbitration.
// What it does: holds the address. A clear (pending or failed nonvolatile
// load) overrides both write paths, and the nonvolatile path beats the host
// path. Assumes the write strobes are synchronous to clk.
module ucf_sta_reg
    import ucf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W = ADDR_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_pend,
    input  logic              nv_err,
    input  logic              nv_we,
    input  logic [ADDR_W-1:0] nv_data,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_data,
    output logic [ADDR_W-1:0] sta_q
);
    addr_src_e src;

    // Choose which source drives the register this cycle.
    always_comb begin
        if (nv_pend || nv_err) src = SRC_CLEAR;
        else if (nv_we)        src = SRC_NVM;
        else if (host_we)      src = SRC_HOST;
        else                   src = SRC_HOLD;
    end

    // Update the register from the chosen source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_q <= '0;
        end else begin
            case (src)
                SRC_CLEAR: sta_q <= '0;
                SRC_NVM:   sta_q <= nv_data;
                SRC_HOST:  sta_q <= host_data;
                default:   sta_q <= sta_q;
            endcase
        end
    end
endmodule

// File: rtl/ucf_byte_cmp.sv
// Incremental destination-address comparator.
// What it does: copies the station address at start-of-frame and compares
// each later valid byte against its lane of that copy. It keeps a sticky
// mismatch flag and reports the strobe of the last address byte.
// Assumes rx_sof is qualified by rx_vld and that ADDR_BYTES >= 2.
module ucf_byte_cmp
    import ucf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W = ADDR_BYTES * BYTE_W,
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_vld,
    input  byte_t             rx_data,
    input  logic [ADDR_W-1:0] sta,
    output logic              last_stb,
    output logic              last_mism,
    output logic              ucast_q
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] DONE_IDX = CNT_W'(ADDR_BYTES);

    logic [CNT_W-1:0]      cnt_q;
    logic [ADDR_W-1:0]     snap_q;
    logic                  mism_q;
    logic [ADDR_BYTES-1:0] lane_diff;
    logic                  cur_diff;
    logic                  sof_diff;
    logic                  in_addr;

    // One comparator per byte lane of the frame copy.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        assign lane_diff[g] = (rx_data != snap_q[g*BYTE_W +: BYTE_W]);
    end

    // Pick the lane that belongs to the current byte position.
    always_comb begin
        cur_diff = 1'b0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (cnt_q == CNT_W'(i)) cur_diff = lane_diff[i];
        end
    end

    assign sof_diff  = (rx_data != sta[BYTE_W-1:0]);
    assign in_addr   = rx_vld && !rx_sof && (cnt_q != '0) && (cnt_q < DONE_IDX);
    assign last_stb  = in_addr && (cnt_q == LAST_IDX);
    assign last_mism = mism_q || cur_diff;

    // Track byte position, the frame copy, the mismatch and the unicast bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            snap_q  <= '0;
            mism_q  <= 1'b0;
            ucast_q <= 1'b0;
        end else if (rx_vld && rx_sof) begin
            cnt_q   <= CNT_W'(1);
            snap_q  <= sta;
            mism_q  <= sof_diff;
            ucast_q <= ~rx_data[0];
        end else if (in_addr) begin
            cnt_q   <= cnt_q + CNT_W'(1);
            mism_q  <= last_mism;
        end
    end
endmodule

// File: rtl/ucf_decide.sv
// Decision stage. It turns the last-byte strobe into a one-cycle decision
// pulse and an accept flag. Assumes last_stb is at most one cycle wide.
module ucf_decide (
    input  logic clk,
    input  logic rst_n,
    input  logic last_stb,
    input  logic last_mism,
    input  logic ucast,
    input  logic dis,
    output logic dec_vld,
    output logic accept
);
    // Register the decision for the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld <= 1'b0;
            accept  <= 1'b0;
        end else begin
            dec_vld <= last_stb;
            accept  <= last_stb && ucast && !last_mism && !dis;
        end
    end
endmodule

// File: rtl/ucf_top.sv
// Unicast destination address filter, top level.
// What it does: connects the station register, the byte comparator and the
// decision stage. Assumes one byte per rx_vld and rx_sof on the first byte.
module ucf_top
    import ucf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W = ADDR_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_vld,
    input  logic [7:0]        rx_data,
    input  logic              ucast_dis,
    input  logic              nv_pend,
    input  logic              nv_err,
    input  logic              nv_we,
    input  logic [ADDR_W-1:0] nv_data,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_data,
    output logic [ADDR_W-1:0] sta_addr,
    output logic              is_ucast,
    output logic              dec_vld,
    output logic              accept
);
    logic last_stb;
    logic last_mism;

    ucf_sta_reg #(.ADDR_BYTES(ADDR_BYTES)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nv_pend   (nv_pend),
        .nv_err    (nv_err),
        .nv_we     (nv_we),
        .nv_data   (nv_data),
        .host_we   (host_we),
        .host_data (host_data),
        .sta_q     (sta_addr)
    );

    ucf_byte_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_sof    (rx_sof),
        .rx_vld    (rx_vld),
        .rx_data   (rx_data),
        .sta       (sta_addr),
        .last_stb  (last_stb),
        .last_mism (last_mism),
        .ucast_q   (is_ucast)
    );

    ucf_decide u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_stb  (last_stb),
        .last_mism (last_mism),
        .ucast     (is_ucast),
        .dis       (ucast_dis),
        .dec_vld   (dec_vld),
        .accept    (accept)
    );
endmodule

// File: rtl/ucf_checker.sv
// Port-level properties of the filter, attached to ucf_top through a bind.
module ucf_checker #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ucast_dis,
    input logic              nv_pend,
    input logic              nv_err,
    input logic              nv_we,
    input logic [ADDR_W-1:0] nv_data,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_data,
    input logic [ADDR_W-1:0] sta_addr,
    input logic              is_ucast,
    input logic              dec_vld,
    input logic              accept
);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_pend || nv_err) |=> (sta_addr == '0));

    p_nv_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nv_pend && !nv_err && nv_we) |=> (sta_addr == $past(nv_data)));

    p_host_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nv_pend && !nv_err && !nv_we && host_we) |=> (sta_addr == $past(host_data)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nv_pend && !nv_err && !nv_we && !host_we) |=> $stable(sta_addr));

    p_accept_in_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> dec_vld);

    p_dec_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld);

    p_mcast_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> is_ucast);

    p_disable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && $past(ucast_dis)) |-> !accept);
endmodule

bind ucf_top ucf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ucast_dis (ucast_dis),
    .nv_pend   (nv_pend),
    .nv_err    (nv_err),
    .nv_we     (nv_we),
    .nv_data   (nv_data),
    .host_we   (host_we),
    .host_data (host_data),
    .sta_addr  (sta_addr),
    .is_ucast  (is_ucast),
    .dec_vld   (dec_vld),
    .accept    (accept)
);

// File: tb/ucf_top_tb_top.sv
// Scoreboard bench: the frame driver pushes the expected accept bit and the
// monitor pops it on every decision pulse.
module ucf_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_sof, rx_vld, ucast_dis, nv_pend, nv_err, nv_we, host_we;
    logic [7:0]  rx_data;
    logic [47:0] nv_data, host_data, sta_addr;
    logic        is_ucast, dec_vld, accept;

    int checks = 0;
    int fails  = 0;
    logic exp_q[$];
    logic [47:0] tb_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    ucf_top dut_i (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_vld(rx_vld),
        .rx_data(rx_data), .ucast_dis(ucast_dis), .nv_pend(nv_pend),
        .nv_err(nv_err), .nv_we(nv_we), .nv_data(nv_data),
        .host_we(host_we), .host_data(host_data), .sta_addr(sta_addr),
        .is_ucast(is_ucast), .dec_vld(dec_vld), .accept(accept)
    );

    task automatic check(input bit ok, input string req, input logic [47:0] act,
                         input logic [47:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each decision against the scoreboard queue (R7, R8).
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (accept && !dec_vld) check(1'b0, "R7 accept without decision", 48'(accept), 48'd0);
            if (dec_vld) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected decision", 48'(accept), 48'd0);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    check(accept == e, "R7 accept decision", 48'(accept), 48'(e));
                end
            end
        end
    end

    task automatic do_load(input bit pend, input bit err, input bit nvw,
                           input logic [47:0] nd, input bit hw,
                           input logic [47:0] hd, input string req);
        @(negedge clk);
        nv_pend = pend; nv_err = err; nv_we = nvw; nv_data = nd;
        host_we = hw; host_data = hd;
        if (pend || err) tb_addr = '0;
        else if (nvw)    tb_addr = nd;
        else if (hw)     tb_addr = hd;
        @(negedge clk);
        nv_pend = 0; nv_err = 0; nv_we = 0; host_we = 0;
        check(sta_addr == tb_addr, req, sta_addr, tb_addr);
    endtask

    // Driver: send one frame; push the expected result when a decision is due.
    task automatic send_frame(input logic [47:0] da, input int len, input bit dis,
                              input int gap, input int mid_at,
                              input logic [47:0] mid_data, input string req);
        if (len >= 6) exp_q.push_back((da[0] == 1'b0) && (da == tb_addr) && !dis);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_vld = 1; rx_sof = (i == 0);
            rx_data = (i < 6) ? da[8*i +: 8] : 8'hA5;
            ucast_dis = dis;
            host_we = (i == mid_at); host_data = mid_data;
            if (i == mid_at) tb_addr = mid_data;
            for (int k = 0; k < gap; k++) begin
                @(negedge clk);
                rx_vld = 0; rx_sof = 0; host_we = 0;
            end
        end
        @(negedge clk);
        rx_vld = 0; rx_sof = 0; host_we = 0;
        if (len > 0) check(is_ucast == ~da[0], {req, " R1 unicast flag"},
                           48'(is_ucast), 48'(~da[0]));
        ucast_dis = 0;
    endtask

    localparam logic [47:0] ADR_A = 48'h0A0B0C0D0E10;
    localparam logic [47:0] ADR_B = 48'h112233445566;
    localparam logic [47:0] ADR_C = 48'hCCBBAA998802;
    localparam logic [47:0] ADR_D = 48'h1F2E3D4C5B6A;
    localparam logic [47:0] ADR_M = 48'h0000000000AB;

    bit finished = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 48'd0, 48'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rx_sof = 0; rx_vld = 0; rx_data = 0; ucast_dis = 0;
        nv_pend = 0; nv_err = 0; nv_we = 0; host_we = 0;
        nv_data = '0; host_data = '0; tb_addr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(sta_addr == '0, "R5 reset address", sta_addr, '0);
        check(is_ucast == 0, "R1 reset flag", 48'(is_ucast), 48'd0);
        check(dec_vld == 0, "R7 reset decision", 48'(dec_vld), 48'd0);

        // R8: bytes before any start-of-frame give no decision.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); rx_vld = 1; rx_sof = 0; rx_data = 8'h00;
        end
        @(negedge clk); rx_vld = 0;
        repeat (2) @(negedge clk);

        do_load(1, 0, 1, ADR_A, 0, '0, "R5 pending load clears");
        do_load(0, 0, 1, ADR_A, 0, '0, "R6 nonvolatile load");
        do_load(0, 0, 1, ADR_B, 1, ADR_C, "R6 nonvolatile wins");
        do_load(0, 0, 0, '0, 1, ADR_C, "R6 host load");

        send_frame(ADR_C, 6, 0, 0, -1, '0, "R2 exact match");
        send_frame(ADR_C ^ 48'h010000000000, 6, 0, 0, -1, '0, "R7 last byte differs");
        send_frame(ADR_C ^ 48'h000000000040, 6, 0, 0, -1, '0, "R7 first byte differs");
        send_frame({ADR_C[7:0], ADR_C[15:8], ADR_C[23:16], ADR_C[31:24],
                    ADR_C[39:32], ADR_C[47:40]}, 6, 0, 0, -1, '0, "R2 reversed order");
        send_frame(ADR_C, 6, 1, 0, -1, '0, "R4 disabled");
        send_frame(ADR_C, 8, 0, 2, -1, '0, "R10 gaps and trailing bytes");
        send_frame(ADR_C, 3, 0, 0, -1, '0, "R8 short frame");
        send_frame(ADR_C, 6, 0, 0, -1, '0, "R8 frame after short");
        send_frame(ADR_C, 6, 0, 0, 2, ADR_D, "R9 load mid-frame");
        check(sta_addr == ADR_D, "R9 register updated", sta_addr, ADR_D);
        send_frame(ADR_D, 6, 0, 0, 0, ADR_C, "R9 load on sof byte");
        send_frame(ADR_C, 6, 0, 0, -1, '0, "R9 new address applies");

        do_load(0, 0, 0, '0, 1, ADR_M, "R6 host load multicast");
        send_frame(ADR_M, 6, 0, 0, -1, '0, "R3 multicast never accepted");

        do_load(0, 1, 0, '0, 0, '0, "R5 read error clears");
        send_frame(48'h0, 6, 0, 0, -1, '0, "R5 zero address match");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8 every expected decision seen",
              48'(exp_q.size()), 48'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule